// File: doc/BRIEF.md
# Parallel ATA PIO Register Access Engine

This block carries out one task-file register access at a time on a parallel ATA bus using programmed I/O. The client side offers a transfer: a read or write flag, a block select, a three-bit register address and a 16-bit write word. The engine then steps the bus through a fixed sequence. First the address and chip select are set up. Then the read or write strobe is held for a pulse. Then address, chip select and write data are held. A recovery gap at the end keeps the full bus cycle at or above the minimum cycle time. The phase lengths are compile-time clock counts, chosen by the integrator to meet mode-2 PIO timing at the system clock. No mode negotiation takes place at run time.

The device can slow an access by holding the IORDY input low. The engine passes IORDY through a synchronizer and keeps the strobe asserted until it is seen high, but only up to a bounded number of extra cycles. If that limit runs out, the cycle ends normally and is marked as timed out. Read data is captured in the last cycle of the read strobe. It is returned with a one-cycle response pulse, which comes with the timeout flag.

The request side is a valid/ready pair. `req_ready` is high only while the engine is idle. A request is taken on the clock edge where both `req_valid` and `req_ready` are high. The request fields may change freely after that edge. A client holding `req_valid` high while the engine is busy simply waits. The response has no back-pressure: `rsp_valid` is a single-cycle pulse, and the client must take it in that cycle.

Top module: `ide_pio_engine`

## Requirements
- R1: Out of reset, `req_ready` is 1, both strobes are high, `ide_cs_n` is 2'b11, `rsp_valid` is 0, and the data bus is not driven.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until the cycle has fully ended. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R3: For SETUP_CYC cycles before the strobe asserts, the address and chip select are driven with both strobes high. Block select 0 drives `ide_cs_n` = 2'b10 and block select 1 drives 2'b01. The address equals `req_addr`.
- R4: A read asserts only `ide_dior_n` low, and a write asserts only `ide_diow_n` low. The strobe stays low for at least PULSE_CYC cycles, and for exactly PULSE_CYC cycles when IORDY stays high.
- R5: IORDY is seen after SYNC_STAGES flops. If IORDY is low when the access starts and rises after the strobe has been low for W sampled cycles, the strobe is low for max(PULSE_CYC, W+SYNC_STAGES) cycles.
- R6: The strobe is never low for more than PULSE_CYC+IORDY_MAX_CYC cycles. If synchronized IORDY is still low in the last allowed cycle, the strobe ends there and `rsp_timeout` is 1 with `rsp_valid`. Otherwise `rsp_timeout` is 0.
- R7: After the strobe deasserts, the address and chip select stay driven for HOLD_CYC cycles. On a write, the data word stays on the bus through those cycles.
- R8: The engine drives the data bus only from setup through hold of a write. At all other times it releases the bus.
- R9: Read data is the bus value in the final cycle of the read strobe and appears on `rsp_rdata` with `rsp_valid`.
- R10: The data register (block 0, address 0) moves all 16 bits. Any other register moves only the low byte: a write drives the upper byte as 0, and a read returns the upper byte as 0.
- R11: `rsp_valid` comes in the first cycle after hold. `req_ready` returns after RECOV_CYC cycles counted from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_blk | input | 1 | 0 = command block, 1 = control block |
| req_addr | input | 3 | Register address within the block |
| req_wdata | input | 16 | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| rsp_timeout | output | 1 | IORDY limit reached on this cycle |
| ide_addr | output | 3 | Bus register address |
| ide_cs_n | output | 2 | Chip selects, active low (bit 0 command block, bit 1 control block) |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_iordy | input | 1 | Device ready, low stretches the strobe |
| ide_data | inout | 16 | Tri-state data bus |

## Verification
The bench drives IORDY low for different numbers of strobe cycles. These include a release that comes too early to matter, a release exactly at the cycle limit, and a release one cycle past it. An off-by-one in the stretch or timeout compare would show up as a strobe that is one cycle long or short, or as a timeout flag that is set wrongly. Read data is changed partway through the strobe, so a capture taken at the start of the pulse returns a stale word. The bench also writes the low-byte registers with nonzero upper bytes, which catches a missing byte mask. It probes the bus after each write to find an engine that keeps driving after hold. Finally, some requests keep `req_valid` high across the whole transfer, so an engine that accepts a second request while busy would show a second response.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RECOV = 3'd4
  } ide_phase_e;

  // register that carries a full 16-bit word (command block only)
  localparam logic [2:0] WIDE_REG_ADDR = 3'd0;
  localparam int         BYTE_W        = 8;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ide_iordy_sync.sv
module ide_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] flops;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flops <= '1;
        end else if (STAGES == 1) begin
          flops <= async_in;
        end else begin
          flops <= {flops[STAGES-2:0], async_in};
        end
      end
      assign sync_out = flops[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ide_phase_ctrl.sv
module ide_phase_ctrl
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC     = 3,
  parameter int PULSE_CYC     = 10,
  parameter int HOLD_CYC      = 2,
  parameter int RECOV_CYC     = 8,
  parameter int IORDY_MAX_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       iordy_s,
  output ide_phase_e phase,
  output logic       cap_en,
  output logic       rsp_valid,
  output logic       rsp_timeout
);
  localparam int LONGEST = max2(max2(SETUP_CYC, PULSE_CYC + IORDY_MAX_CYC),
                                max2(HOLD_CYC, RECOV_CYC));
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_MIN  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_CAP  = CNT_W'(PULSE_CYC + IORDY_MAX_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CYC - 1);

  ide_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             leave_pulse, at_cap, fire_rsp;
  logic             tmo_q, rsp_q;

  assign at_cap      = (cnt_q == PULSE_CAP);
  assign leave_pulse = (ph_q == PH_PULSE) &&
                       (((cnt_q >= PULSE_MIN) && iordy_s) || at_cap);
  assign fire_rsp    = (ph_q == PH_HOLD) && (cnt_q == HOLD_LAST);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) ph_d = PH_SETUP;
      end
      PH_SETUP: if (cnt_q == SETUP_LAST) begin
        ph_d  = PH_PULSE;
        cnt_d = '0;
      end
      PH_PULSE: if (leave_pulse) begin
        ph_d  = PH_HOLD;
        cnt_d = '0;
      end
      PH_HOLD: if (fire_rsp) begin
        ph_d  = PH_RECOV;
        cnt_d = '0;
      end
      PH_RECOV: if (cnt_q == RECOV_LAST) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tmo_q <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rsp_q <= fire_rsp;
      if (leave_pulse) tmo_q <= !iordy_s;
    end
  end

  assign phase       = ph_q;
  assign cap_en      = leave_pulse;
  assign rsp_valid   = rsp_q;
  assign rsp_timeout = tmo_q;
endmodule

// File: rtl/ide_bus_if.sv
module ide_bus_if
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              req_write,
  input  logic              req_blk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  ide_phase_e        phase,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] ide_addr,
  output logic [1:0]        ide_cs_n,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic              wr_q, blk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wide, on_bus, strobing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      blk_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      wr_q    <= req_write;
      blk_q   <= req_blk;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign wide     = !blk_q && (addr_q == ADDR_W'(WIDE_REG_ADDR));
  assign on_bus   = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
  assign strobing = (phase == PH_PULSE);

  assign ide_addr   = addr_q;
  assign ide_cs_n   = on_bus ? (blk_q ? 2'b01 : 2'b10) : 2'b11;
  assign ide_dior_n = !(strobing && !wr_q);
  assign ide_diow_n = !(strobing && wr_q);
  assign bus_oe     = on_bus && wr_q;
  assign bus_out    = wide ? wdata_q : {{HI_W{1'b0}}, wdata_q[BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en && !wr_q) begin
      rdata <= wide ? bus_in : {{HI_W{1'b0}}, bus_in[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 16,
  parameter int SETUP_CYC     = 3,
  parameter int PULSE_CYC     = 10,
  parameter int HOLD_CYC      = 2,
  parameter int RECOV_CYC     = 8,
  parameter int IORDY_MAX_CYC = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_blk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic [ADDR_W-1:0] ide_addr,
  output logic [1:0]        ide_cs_n,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  input  logic              ide_iordy,
  inout  wire  [DATA_W-1:0] ide_data
);
  ide_phase_e        phase;
  logic              iordy_s, cap_en, take, data_oe;
  logic [DATA_W-1:0] data_out;

  assign req_ready = (phase == PH_IDLE);
  assign take      = req_valid && req_ready;
  assign ide_data  = data_oe ? data_out : {DATA_W{1'bz}};

  ide_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ide_iordy), .sync_out(iordy_s)
  );

  ide_phase_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .RECOV_CYC(RECOV_CYC), .IORDY_MAX_CYC(IORDY_MAX_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(take), .iordy_s(iordy_s),
    .phase(phase), .cap_en(cap_en), .rsp_valid(rsp_valid),
    .rsp_timeout(rsp_timeout)
  );

  ide_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .take(take),
    .req_write(req_write), .req_blk(req_blk), .req_addr(req_addr),
    .req_wdata(req_wdata), .phase(phase), .cap_en(cap_en),
    .bus_in(ide_data), .bus_out(data_out), .bus_oe(data_oe),
    .ide_addr(ide_addr), .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n),
    .ide_diow_n(ide_diow_n), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/ide_pio_chk.sv
module ide_pio_chk #(
  parameter int PULSE_CYC     = 10,
  parameter int IORDY_MAX_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] ide_cs_n,
  input logic       ide_dior_n,
  input logic       ide_diow_n,
  input logic       data_oe,
  input logic       rsp_valid
);
  localparam int RUN_W = $clog2(PULSE_CYC + IORDY_MAX_CYC + 2);

  logic             strobe_low;
  logic [RUN_W-1:0] run_len;

  assign strobe_low = !ide_dior_n || !ide_diow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (strobe_low) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));
  // R3
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> (ide_cs_n != 2'b11));
  // R4
  pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(!strobe_low) |-> (run_len >= RUN_W'(PULSE_CYC)));
  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> (run_len < RUN_W'(PULSE_CYC + IORDY_MAX_CYC)));
  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ide_cs_n == 2'b11 && ide_dior_n && ide_diow_n));
  // R8
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_dior_n |-> !data_oe);
endmodule

bind ide_pio_engine ide_pio_chk #(
  .PULSE_CYC(PULSE_CYC), .IORDY_MAX_CYC(IORDY_MAX_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
  .data_oe(data_oe), .rsp_valid(rsp_valid)
);

// File: tb/tb_ide_pio_engine.sv
module tb_ide_pio_engine;
  localparam int S  = 3;
  localparam int P  = 10;
  localparam int H  = 2;
  localparam int RC = 8;
  localparam int MX = 16;
  localparam int SY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_blk = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic [2:0]  ide_addr;
  logic [1:0]  ide_cs_n;
  logic        ide_dior_n, ide_diow_n;
  logic        ide_iordy = 1'b1;
  logic        probe_en = 1'b0;
  logic [15:0] dev_word = '0;
  wire  [15:0] ide_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  assign ide_data = (!ide_dior_n || probe_en) ? dev_word : 16'hzzzz;

  always #5 clk = ~clk;

  ide_pio_engine #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .RECOV_CYC(RC),
                   .IORDY_MAX_CYC(MX), .SYNC_STAGES(SY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_blk(req_blk), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .ide_addr(ide_addr), .ide_cs_n(ide_cs_n),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n), .ide_iordy(ide_iordy),
    .ide_data(ide_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input bit blk, input logic [2:0] a,
                                            input logic [15:0] v);
    return (!blk && a == 3'd0) ? v : {8'h00, v[7:0]};
  endfunction

  function automatic int exp_pulse(input int w);
    int len;
    if (w == 0) return P;
    len = (w + SY > P) ? w + SY : P;
    return (len > P + MX) ? P + MX : len;
  endfunction

  task automatic xfer(input bit wr, input bit blk, input logic [2:0] a,
                      input logic [15:0] wd, input logic [15:0] rd, input int w,
                      input bit keep_valid);
    int sc = 0, pc = 0, hc = 0, rcnt = 0, rsps = 0, pin_err = 0, bus_err = 0;
    int strobe_err = 0;
    logic [15:0] exp_bus, got_rd;
    bit got_tmo, exp_tmo;
    exp_bus = lane_mask(blk, a, wd);
    exp_tmo = (w > 0) && (w + SY > P + MX);
    got_rd = '0; got_tmo = 0;
    dev_word = ~rd;
    if (w > 0) begin
      @(negedge clk); ide_iordy = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_blk = blk; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (!keep_valid) req_valid = 1'b0;
    req_addr = ~a; req_wdata = ~wd; req_blk = ~blk;
    forever begin
      if (!ide_dior_n || !ide_diow_n) begin
        pc++;
        if (wr ? ide_diow_n == 1'b0 && ide_dior_n : ide_dior_n == 1'b0 && ide_diow_n)
          ; else strobe_err++;
        if (wr && ide_data !== exp_bus) bus_err++;
        if (!wr && pc == 2) dev_word = rd;
        if (w > 0 && pc == w) ide_iordy = 1'b1;
      end else if (ide_cs_n != 2'b11) begin
        if (pc == 0) sc++; else hc++;
        if (wr && ide_data !== exp_bus) bus_err++;
      end
      if (ide_cs_n != 2'b11 &&
          (ide_addr != a || ide_cs_n != (blk ? 2'b01 : 2'b10))) pin_err++;
      if (rsp_valid) begin
        rsps++; got_rd = rsp_rdata; got_tmo = rsp_timeout; req_valid = 1'b0;
      end
      if (rsps > 0 && !req_ready) rcnt++;
      if (rsps > 0 && req_ready) break;
      @(negedge clk);
    end
    ide_iordy = 1'b1;
    chk(sc == S, "R3 setup length", sc, S);
    chk(pin_err == 0, "R3 address/select", pin_err, 0);
    chk(strobe_err == 0, "R4 strobe choice", strobe_err, 0);
    if (w == 0)       chk(pc == exp_pulse(w), "R4 pulse length", pc, exp_pulse(w));
    else if (exp_tmo) chk(pc == exp_pulse(w), "R6 capped pulse", pc, exp_pulse(w));
    else              chk(pc == exp_pulse(w), "R5 stretched pulse", pc, exp_pulse(w));
    chk(got_tmo == exp_tmo, "R6 timeout flag", got_tmo, exp_tmo);
    chk(hc == H, "R7 hold length", hc, H);
    chk(rsps == 1, "R2 one response", rsps, 1);
    chk(rcnt == RC, "R11 recovery", rcnt, RC);
    if (wr) chk(bus_err == 0, "R10 R7 write word on bus", bus_err, 0);
    else    chk(got_rd == lane_mask(blk, a, rd), "R9 R10 read data", got_rd,
                lane_mask(blk, a, rd));
    probe_en = 1'b1; dev_word = ~exp_bus;
    @(negedge clk);
    chk(ide_data === ~exp_bus, "R8 bus released", ide_data, ~exp_bus);
    probe_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1d3e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(ide_cs_n == 2'b11, "R1 selects", ide_cs_n, 2'b11);
    chk(ide_dior_n && ide_diow_n, "R1 strobes", {ide_dior_n, ide_diow_n}, 2'b11);
    chk(rsp_valid == 1'b0, "R1 response", rsp_valid, 0);
    probe_en = 1'b1; dev_word = 16'h5a3c;
    @(negedge clk);
    chk(ide_data === 16'h5a3c, "R1 bus idle", ide_data, 16'h5a3c);
    probe_en = 1'b0;

    xfer(1, 0, 3'd0, 16'hbeef, 16'h0, 0, 0);   // wide write
    xfer(0, 0, 3'd0, 16'h0, 16'hc0de, 0, 0);   // wide read
    xfer(1, 0, 3'd7, 16'hab50, 16'h0, 0, 0);   // byte register write
    xfer(0, 1, 3'd6, 16'h0, 16'h9a51, 0, 1);   // control block read, valid held
    xfer(0, 0, 3'd7, 16'h0, 16'h1280, 5, 0);   // short IORDY low: no stretch
    xfer(1, 0, 3'd0, 16'h1234, 16'h0, 12, 0);  // stretch
    xfer(0, 0, 3'd0, 16'h0, 16'h7e57, P + MX - SY, 0);     // at the cap
    xfer(0, 0, 3'd1, 16'h0, 16'hfe01, P + MX - SY + 1, 0); // one past: timeout
    xfer(1, 1, 3'd6, 16'h0f0f, 16'h0, 40, 1);  // long timeout on write

    for (int i = 0; i < 40; i++) begin
      int sel, w;
      sel = $urandom % 4;
      case (sel)
        0: w = 0;
        1: w = 1 + $urandom % 8;
        2: w = 8 + $urandom % 14;
        default: w = 20 + $urandom % 10;
      endcase
      xfer($urandom % 2, $urandom % 2, 3'($urandom % 8), 16'($urandom),
           16'($urandom), w, $urandom % 2);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule